// File: doc/BRIEF.md
# Packet Start Token Framer and Checker

This block handles the start-of-packet tokens that mark transaction packets and link packets inside a scrambled-free, byte-wide symbol stream. On the transmit side it accepts a framing request carrying a packet kind, a length and a sequence number. It then emits the start token one symbol per cycle. Between tokens it forwards payload symbols from the packet source, and it pads every empty slot with the logical-idle symbol.

On the receive side it walks the incoming symbol stream. It decodes each transaction token into its length and sequence number and confirms the length's check bits and parity. It then delivers the packet body, and finds the end of the packet by counting doublewords, because no end marker is present. Slots where the valid input is low stand for block sync headers. The length count skips them, so a packet may run across a block boundary. Any framing fault raises a one-cycle error pulse and parks the receiver. It delivers nothing more until a recovery-complete pulse arrives.

Top module: `pkt_frame_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, all receive pulses are low, `rx_halted` is low, `tx_sym` is 00h and `tx_rdy` is high.
- R2: A transaction request accepted while `tx_rdy` is high produces four token symbols on `tx_sym`, starting the cycle after the request. The symbols are {len[3:0],4'hF}, then {P,len[10:4]}, then {C[3:0],seq[11:8]}, then seq[7:0]. C is the remainder of len·x^4 divided by x^4+x+1. P makes the count of ones over len, C and P odd.
- R3: A link-packet request accepted while `tx_rdy` is high produces F0h and then ACh on the two cycles that follow.
- R4: With no token pending, `tx_sym` shows last cycle's `tx_pay` when `tx_pay_vld` was high, and 00h otherwise. While a token is being sent, `tx_rdy` is low, and requests and payload are ignored.
- R5: After the fourth symbol of a valid transaction token, `rx_tlp_sop` pulses one cycle later with the decoded length and sequence number.
- R6: The len·4−4 symbols after a transaction token are delivered on `rx_pay` with `rx_pay_vld`, one cycle after each arrives. `rx_eop` marks the last of them, for every length from 5 to 1031.
- R7: Cycles with `rx_vld` low are skipped. They produce no output and do not advance the token or length count.
- R8: F0h followed by ACh pulses `rx_dllp_sop` one cycle after the ACh. The next six symbols are delivered as body, with `rx_eop` on the sixth.
- R9: The idle symbol 00h in a packet-start slot produces no output and no error.
- R10: A start-slot symbol that is not a transaction start (low nibble Fh), F0h, 00h or an allowed C0h raises `rx_frm_err` one cycle later. So does F0h followed by anything other than ACh.
- R11: When the third transaction token symbol shows wrong check bits, wrong parity, or a length outside 5..1031, `rx_frm_err` pulses one cycle later and no start pulse follows.
- R12: The end-bad symbol C0h is accepted silently only in the slot right after a transaction packet's last symbol. In any other start slot it is a framing error.
- R13: From an error until `rx_recov_done`, `rx_halted` is high and no start, body or error output appears. The cycle after `rx_recov_done`, `rx_halted` is low and the next symbol is taken as a packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Request to send a start token |
| tx_is_tlp | input | 1 | 1: transaction token, 0: link-packet token |
| tx_len | input | 11 | Transaction length in doublewords |
| tx_seq | input | 12 | Transaction sequence number |
| tx_pay_vld | input | 1 | Payload symbol present |
| tx_pay | input | 8 | Payload symbol |
| tx_rdy | output | 1 | No token in progress; request may be taken |
| tx_sym | output | 8 | Transmit symbol stream |
| rx_vld | input | 1 | Receive symbol present (low during sync header) |
| rx_sym | input | 8 | Receive symbol |
| rx_recov_done | input | 1 | Recovery finished; leave halt |
| rx_tlp_sop | output | 1 | Valid transaction token seen |
| rx_tlp_len | output | 11 | Decoded length, valid with rx_tlp_sop |
| rx_tlp_seq | output | 12 | Decoded sequence number, valid with rx_tlp_sop |
| rx_dllp_sop | output | 1 | Link-packet token seen |
| rx_pay_vld | output | 1 | Body symbol on rx_pay |
| rx_pay | output | 8 | Body symbol |
| rx_eop | output | 1 | Last body symbol of the packet |
| rx_frm_err | output | 1 | Framing error pulse |
| rx_halted | output | 1 | Receiver parked after an error |

## Verification
Every receive result is registered once. It is due on the cycle after the symbol that causes it, and a gap cycle produces nothing. Every transmit symbol is due on the cycle after the request or payload that causes it, and a token then occupies the following consecutive cycles. The bench drives one input set per cycle and advances its queue-based model by the same cycle. It compares the full output set on the next falling edge. Each expectation therefore belongs to exactly one input cycle, including the error and recovery cycles.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

    localparam int SYM_W = 8;
    localparam int LEN_W = 11;
    localparam int SEQ_W = 12;
    localparam int CRC_W = 4;
    localparam int CNT_W = LEN_W + 2;
    localparam int LINK_BODY = 6;

    localparam logic [SYM_W-1:0] SYM_IDLE  = 8'h00;
    localparam logic [SYM_W-1:0] SYM_LNK_A = 8'hF0;
    localparam logic [SYM_W-1:0] SYM_LNK_B = 8'hAC;
    localparam logic [SYM_W-1:0] SYM_BAD   = 8'hC0;
    localparam logic [3:0]       TLP_NIB   = 4'hF;
    localparam logic [CRC_W-1:0] CRC_POLY  = 4'h3;

    typedef enum logic [2:0] {
        RX_START,
        RX_TOK1,
        RX_TOK2,
        RX_TOK3,
        RX_LNK1,
        RX_BODY,
        RX_HALT
    } rx_state_e;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_TLP,
        SC_LNK,
        SC_EBAD,
        SC_ILLEGAL
    } sym_class_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [SEQ_W-1:0] seq;
    } tlp_hdr_t;

    function automatic logic [CRC_W-1:0] len_crc(input logic [LEN_W-1:0] len);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = LEN_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ len[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

    function automatic logic odd_par(input logic [LEN_W-1:0] len,
                                     input logic [CRC_W-1:0] crc);
        return ~(^{len, crc});
    endfunction

    function automatic sym_class_e classify(input logic [SYM_W-1:0] s);
        if (s[3:0] == TLP_NIB)  return SC_TLP;
        if (s == SYM_LNK_A)     return SC_LNK;
        if (s == SYM_IDLE)      return SC_IDLE;
        if (s == SYM_BAD)       return SC_EBAD;
        return SC_ILLEGAL;
    endfunction

    function automatic logic [4*SYM_W-1:0] tlp_token(input tlp_hdr_t h);
        logic [CRC_W-1:0] c;
        c = len_crc(h.len);
        return {h.seq[7:0],
                c, h.seq[11:8],
                odd_par(h.len, c), h.len[10:4],
                h.len[3:0], TLP_NIB};
    endfunction

endpackage

// File: rtl/pfu_len_guard.sv
module pfu_len_guard
    import pkt_frame_pkg::*;
#(
    parameter int LEN_MIN = 5,
    parameter int LEN_MAX = 1031
) (
    input  logic [LEN_W-1:0] i_len,
    input  logic [CRC_W-1:0] i_crc,
    input  logic             i_par,
    output logic             o_ok
);
    logic crc_ok, par_ok, rng_ok;

    always_comb begin
        crc_ok = (i_crc == len_crc(i_len));
        par_ok = (^{i_len, i_crc, i_par}) == 1'b1;
        rng_ok = (int'(i_len) >= LEN_MIN) && (int'(i_len) <= LEN_MAX);
        o_ok   = crc_ok && par_ok && rng_ok;
    end
endmodule

// File: rtl/pfu_tx_tokens.sv
module pfu_tx_tokens
    import pkt_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             i_req,
    input  logic             i_is_tlp,
    input  logic [LEN_W-1:0] i_len,
    input  logic [SEQ_W-1:0] i_seq,
    input  logic             i_pay_vld,
    input  logic [SYM_W-1:0] i_pay,
    output logic             o_rdy,
    output logic [SYM_W-1:0] o_sym
);
    localparam int REST_W = 3 * SYM_W;

    logic [1:0]         left_q;
    logic [REST_W-1:0]  rest_q;
    logic [4*SYM_W-1:0] tok;
    tlp_hdr_t           hdr;

    always_comb begin
        hdr.len = i_len;
        hdr.seq = i_seq;
        tok     = tlp_token(hdr);
    end

    assign o_rdy = (left_q == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            rest_q <= '0;
            o_sym  <= SYM_IDLE;
        end else if (left_q != 2'd0) begin
            o_sym  <= rest_q[SYM_W-1:0];
            rest_q <= rest_q >> SYM_W;
            left_q <= left_q - 2'd1;
        end else if (i_req) begin
            if (i_is_tlp) begin
                o_sym  <= tok[SYM_W-1:0];
                rest_q <= tok[4*SYM_W-1:SYM_W];
                left_q <= 2'd3;
            end else begin
                o_sym  <= SYM_LNK_A;
                rest_q <= {{(REST_W-SYM_W){1'b0}}, SYM_LNK_B};
                left_q <= 2'd1;
            end
        end else begin
            o_sym <= i_pay_vld ? i_pay : SYM_IDLE;
        end
    end

    p_tlp_lead_r2: assert property (@(posedge clk) disable iff (rst)
        (i_req && o_rdy && i_is_tlp) |=> (o_sym[3:0] == TLP_NIB && !o_rdy));

    p_lnk_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (i_req && o_rdy && !i_is_tlp) |=> (o_sym == SYM_LNK_A) ##1 (o_sym == SYM_LNK_B));

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!o_rdy) |=> (o_sym != SYM_IDLE || $past(rest_q[SYM_W-1:0]) == SYM_IDLE));
endmodule

// File: rtl/pfu_rx_parse.sv
module pfu_rx_parse
    import pkt_frame_pkg::*;
#(
    parameter int LEN_MIN = 5,
    parameter int LEN_MAX = 1031
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_vld,
    input  logic [SYM_W-1:0] i_sym,
    input  logic             i_recov_done,
    output logic             o_tlp_sop,
    output logic [LEN_W-1:0] o_tlp_len,
    output logic [SEQ_W-1:0] o_tlp_seq,
    output logic             o_dllp_sop,
    output logic             o_pay_vld,
    output logic [SYM_W-1:0] o_pay,
    output logic             o_eop,
    output logic             o_frm_err,
    output logic             o_halted
);
    rx_state_e        st;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       len_lo_q;
    logic [6:0]       len_hi_q;
    logic             par_q;
    logic [3:0]       seq_hi_q;
    logic             after_tlp_q;
    logic             body_tlp_q;
    logic [LEN_W-1:0] cur_len;
    logic             tok_ok;
    sym_class_e       cls;

    assign cur_len  = {len_hi_q, len_lo_q};
    assign cls      = classify(i_sym);
    assign o_halted = (st == RX_HALT);

    pfu_len_guard #(.LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_guard (
        .i_len (cur_len),
        .i_crc (i_sym[7:4]),
        .i_par (par_q),
        .o_ok  (tok_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= RX_START;
            cnt_q       <= '0;
            len_lo_q    <= '0;
            len_hi_q    <= '0;
            par_q       <= 1'b0;
            seq_hi_q    <= '0;
            after_tlp_q <= 1'b0;
            body_tlp_q  <= 1'b0;
            o_tlp_sop   <= 1'b0;
            o_tlp_len   <= '0;
            o_tlp_seq   <= '0;
            o_dllp_sop  <= 1'b0;
            o_pay_vld   <= 1'b0;
            o_pay       <= '0;
            o_eop       <= 1'b0;
            o_frm_err   <= 1'b0;
        end else begin
            o_tlp_sop  <= 1'b0;
            o_dllp_sop <= 1'b0;
            o_pay_vld  <= 1'b0;
            o_eop      <= 1'b0;
            o_frm_err  <= 1'b0;
            if (st == RX_HALT) begin
                after_tlp_q <= 1'b0;
                if (i_recov_done) st <= RX_START;
            end else if (i_vld) begin
                case (st)
                    RX_START: begin
                        after_tlp_q <= 1'b0;
                        case (cls)
                            SC_IDLE: ;
                            SC_TLP: begin
                                len_lo_q <= i_sym[7:4];
                                st       <= RX_TOK1;
                            end
                            SC_LNK: st <= RX_LNK1;
                            SC_EBAD: begin
                                if (!after_tlp_q) begin
                                    o_frm_err <= 1'b1;
                                    st        <= RX_HALT;
                                end
                            end
                            default: begin
                                o_frm_err <= 1'b1;
                                st        <= RX_HALT;
                            end
                        endcase
                    end
                    RX_TOK1: begin
                        len_hi_q <= i_sym[6:0];
                        par_q    <= i_sym[7];
                        st       <= RX_TOK2;
                    end
                    RX_TOK2: begin
                        if (tok_ok) begin
                            seq_hi_q <= i_sym[3:0];
                            st       <= RX_TOK3;
                        end else begin
                            o_frm_err <= 1'b1;
                            st        <= RX_HALT;
                        end
                    end
                    RX_TOK3: begin
                        o_tlp_sop  <= 1'b1;
                        o_tlp_len  <= cur_len;
                        o_tlp_seq  <= {seq_hi_q, i_sym};
                        cnt_q      <= {cur_len, 2'b00} - CNT_W'(4);
                        body_tlp_q <= 1'b1;
                        st         <= RX_BODY;
                    end
                    RX_LNK1: begin
                        if (i_sym == SYM_LNK_B) begin
                            o_dllp_sop <= 1'b1;
                            cnt_q      <= CNT_W'(LINK_BODY);
                            body_tlp_q <= 1'b0;
                            st         <= RX_BODY;
                        end else begin
                            o_frm_err <= 1'b1;
                            st        <= RX_HALT;
                        end
                    end
                    RX_BODY: begin
                        o_pay_vld <= 1'b1;
                        o_pay     <= i_sym;
                        cnt_q     <= cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(1)) begin
                            o_eop       <= 1'b1;
                            after_tlp_q <= body_tlp_q;
                            st          <= RX_START;
                        end
                    end
                    default: st <= RX_HALT;
                endcase
            end
        end
    end

    p_halt_silent_r13: assert property (@(posedge clk) disable iff (rst)
        (st == RX_HALT) |=> !(o_tlp_sop || o_dllp_sop || o_pay_vld || o_frm_err));

    p_halt_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (o_halted && !i_recov_done) |=> o_halted);

    p_sop_range_r11: assert property (@(posedge clk) disable iff (rst)
        o_tlp_sop |-> (int'(o_tlp_len) >= LEN_MIN && int'(o_tlp_len) <= LEN_MAX));

    p_one_event_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({o_tlp_sop, o_dllp_sop, o_pay_vld, o_frm_err}));

    p_eop_in_body_r6: assert property (@(posedge clk) disable iff (rst)
        o_eop |-> o_pay_vld);

    p_gap_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!i_vld) |=> !(o_tlp_sop || o_dllp_sop || o_pay_vld || o_frm_err));

    p_err_parks_r10: assert property (@(posedge clk) disable iff (rst)
        o_frm_err |-> o_halted);
endmodule

// File: rtl/pkt_frame_unit.sv
module pkt_frame_unit
    import pkt_frame_pkg::*;
#(
    parameter int LEN_MIN = 5,
    parameter int LEN_MAX = 1031
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_req,
    input  logic        tx_is_tlp,
    input  logic [10:0] tx_len,
    input  logic [11:0] tx_seq,
    input  logic        tx_pay_vld,
    input  logic [7:0]  tx_pay,
    output logic        tx_rdy,
    output logic [7:0]  tx_sym,
    input  logic        rx_vld,
    input  logic [7:0]  rx_sym,
    input  logic        rx_recov_done,
    output logic        rx_tlp_sop,
    output logic [10:0] rx_tlp_len,
    output logic [11:0] rx_tlp_seq,
    output logic        rx_dllp_sop,
    output logic        rx_pay_vld,
    output logic [7:0]  rx_pay,
    output logic        rx_eop,
    output logic        rx_frm_err,
    output logic        rx_halted
);
    pfu_tx_tokens u_tx (
        .clk       (clk),
        .rst       (rst),
        .i_req     (tx_req),
        .i_is_tlp  (tx_is_tlp),
        .i_len     (tx_len),
        .i_seq     (tx_seq),
        .i_pay_vld (tx_pay_vld),
        .i_pay     (tx_pay),
        .o_rdy     (tx_rdy),
        .o_sym     (tx_sym)
    );

    pfu_rx_parse #(.LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .i_vld        (rx_vld),
        .i_sym        (rx_sym),
        .i_recov_done (rx_recov_done),
        .o_tlp_sop    (rx_tlp_sop),
        .o_tlp_len    (rx_tlp_len),
        .o_tlp_seq    (rx_tlp_seq),
        .o_dllp_sop   (rx_dllp_sop),
        .o_pay_vld    (rx_pay_vld),
        .o_pay        (rx_pay),
        .o_eop        (rx_eop),
        .o_frm_err    (rx_frm_err),
        .o_halted     (rx_halted)
    );
endmodule

// File: tb/pkt_frame_unit_tb_top.sv
`timescale 1ns/1ps
module pkt_frame_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_req = 1'b0, tx_is_tlp = 1'b0, tx_pay_vld = 1'b0;
    logic [10:0] tx_len = '0;
    logic [11:0] tx_seq = '0;
    logic [7:0]  tx_pay = '0;
    logic        tx_rdy;
    logic [7:0]  tx_sym;
    logic        rx_vld = 1'b0, rx_recov_done = 1'b0;
    logic [7:0]  rx_sym = '0;
    logic        rx_tlp_sop, rx_dllp_sop, rx_pay_vld, rx_eop, rx_frm_err, rx_halted;
    logic [10:0] rx_tlp_len;
    logic [11:0] rx_tlp_seq;
    logic [7:0]  rx_pay;

    int total = 0;
    int bad = 0;
    bit m_halt = 0;
    byte unsigned txq[$];

    typedef struct {
        bit tsop; int len; int seq; bit dsop; bit pv; int pay; bit eop; bit err;
    } exp_t;

    always #2 clk = ~clk;

    pkt_frame_unit dut_i (
        .clk(clk), .rst(rst),
        .tx_req(tx_req), .tx_is_tlp(tx_is_tlp), .tx_len(tx_len), .tx_seq(tx_seq),
        .tx_pay_vld(tx_pay_vld), .tx_pay(tx_pay), .tx_rdy(tx_rdy), .tx_sym(tx_sym),
        .rx_vld(rx_vld), .rx_sym(rx_sym), .rx_recov_done(rx_recov_done),
        .rx_tlp_sop(rx_tlp_sop), .rx_tlp_len(rx_tlp_len), .rx_tlp_seq(rx_tlp_seq),
        .rx_dllp_sop(rx_dllp_sop), .rx_pay_vld(rx_pay_vld), .rx_pay(rx_pay),
        .rx_eop(rx_eop), .rx_frm_err(rx_frm_err), .rx_halted(rx_halted)
    );

    function automatic int ref_crc(int len);
        int v = (len & 'h7FF) << 4;
        for (int b = 14; b >= 4; b--)
            if ((v >> b) & 1) v = v ^ ('h13 << (b - 4));
        return v & 'hF;
    endfunction

    function automatic int ref_par(int len, int crc);
        return (($countones(len & 'h7FF) + $countones(crc & 'hF)) % 2 == 0) ? 1 : 0;
    endfunction

    function automatic exp_t ex0();
        exp_t e;
        e.tsop = 0; e.len = 0; e.seq = 0; e.dsop = 0;
        e.pv = 0; e.pay = 0; e.eop = 0; e.err = 0;
        return e;
    endfunction

    task automatic step(string tag, int sym, bit vld, bit done, exp_t e);
        int exp_tx;
        bit exp_rdy;
        logic [45:0] act, expv;
        rx_sym = sym[7:0]; rx_vld = vld; rx_recov_done = done;
        if (txq.size() > 0) begin
            exp_tx = txq.pop_front();
        end else if (tx_req) begin
            if (tx_is_tlp) begin
                int c = ref_crc(tx_len);
                txq.push_back({tx_len[3:0], 4'hF});
                txq.push_back({ref_par(tx_len, c) == 1, tx_len[10:4]});
                txq.push_back({c[3:0], tx_seq[11:8]});
                txq.push_back(tx_seq[7:0]);
            end else begin
                txq.push_back(8'hF0);
                txq.push_back(8'hAC);
            end
            exp_tx = txq.pop_front();
        end else begin
            exp_tx = tx_pay_vld ? tx_pay : 0;
        end
        exp_rdy = (txq.size() == 0);
        if (m_halt) begin
            e = ex0();
            if (done) m_halt = 0;
        end else if (e.err) begin
            m_halt = 1;
        end
        @(posedge clk);
        @(negedge clk);
        act  = {rx_tlp_sop, rx_tlp_sop ? rx_tlp_len : 11'd0, rx_tlp_sop ? rx_tlp_seq : 12'd0,
                rx_dllp_sop, rx_pay_vld, rx_pay_vld ? rx_pay : 8'd0, rx_eop, rx_frm_err,
                rx_halted, tx_sym, tx_rdy};
        expv = {e.tsop, e.tsop ? e.len[10:0] : 11'd0, e.tsop ? e.seq[11:0] : 12'd0,
                e.dsop, e.pv, e.pv ? e.pay[7:0] : 8'd0, e.eop, e.err,
                m_halt, exp_tx[7:0], exp_rdy};
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, expv);
        end
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 8'h00, 1'b1, 1'b0, ex0());
    endtask

    task automatic rx_tlp(string tag, int len, int seq, int crc_x, int par_x, bit gaps);
        exp_t e;
        bit   bd = (crc_x != 0) || (par_x != 0) || (len < 5) || (len > 1031);
        int   c = ref_crc(len) ^ crc_x;
        int   p = ref_par(len, c) ^ par_x;
        int   nb = bd ? 8 : len * 4 - 4;
        step(tag, ((len & 'hF) << 4) | 'hF, 1, 0, ex0());
        step(tag, (p << 7) | ((len >> 4) & 'h7F), 1, 0, ex0());
        if (gaps) step(tag, 8'h55, 0, 0, ex0());
        e = ex0(); e.err = bd;
        step(tag, ((c & 'hF) << 4) | ((seq >> 8) & 'hF), 1, 0, e);
        e = ex0(); e.tsop = 1; e.len = len; e.seq = seq;
        step(tag, seq & 'hFF, 1, 0, e);
        for (int i = 0; i < nb; i++) begin
            if (gaps && (i % 5 == 2)) step(tag, 8'hAA, 0, 0, ex0());
            e = ex0(); e.pv = 1; e.pay = (i ^ 'h5A) & 'hFF; e.eop = (i == nb - 1);
            step(tag, e.pay, 1, 0, e);
        end
    endtask

    task automatic rx_dllp(string tag, int second);
        exp_t e;
        step(tag, 8'hF0, 1, 0, ex0());
        e = ex0();
        if (second == 'hAC) e.dsop = 1; else e.err = 1;
        step(tag, second, 1, 0, e);
        for (int i = 0; i < 6; i++) begin
            e = ex0(); e.pv = 1; e.pay = 'h30 + i; e.eop = (i == 5);
            step(tag, e.pay, 1, 0, e);
        end
    endtask

    task automatic recover();
        step("R13", 8'h00, 1, 1, ex0());
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (rx_tlp_sop || rx_dllp_sop || rx_pay_vld || rx_eop || rx_frm_err || rx_halted
            || tx_sym !== 8'h00 || tx_rdy !== 1'b1) begin
            bad++;
            $display("FAIL R1 reset: actual tx_sym=%h rdy=%b halted=%b expected 00/1/0",
                     tx_sym, tx_rdy, rx_halted);
        end
        rst = 1'b0;
        idle("R1", 1);

        // R2: transaction token, payload offered while busy must be ignored (R4)
        tx_req = 1; tx_is_tlp = 1; tx_len = 11'd6; tx_seq = 12'h123;
        step("R2", 0, 1, 0, ex0());
        tx_req = 0; tx_pay_vld = 1; tx_pay = 8'h11;
        step("R2", 0, 1, 0, ex0());
        tx_req = 1; tx_is_tlp = 0;
        step("R4", 0, 1, 0, ex0());
        tx_req = 0;
        step("R2", 0, 1, 0, ex0());
        tx_pay = 8'h22;
        step("R4", 0, 1, 0, ex0());
        tx_pay_vld = 0;
        step("R4", 0, 1, 0, ex0());
        // R3: link-packet token
        tx_req = 1; tx_is_tlp = 0;
        step("R3", 0, 1, 0, ex0());
        tx_req = 0;
        step("R3", 0, 1, 0, ex0());
        tx_is_tlp = 1; tx_len = 11'd1031; tx_seq = 12'hFED; tx_req = 1;
        step("R2", 0, 1, 0, ex0());
        tx_req = 0;
        idle("R2", 4);

        // R5, R6, R9, R12: minimal TLP then end-bad right after it
        idle("R9", 2);
        rx_tlp("R5", 5, 'hABC, 0, 0, 0);
        step("R12", 8'hC0, 1, 0, ex0());
        idle("R9", 1);
        // R7: sync gaps inside token and body, then R8 right after TLP end
        rx_tlp("R7", 7, 'h001, 0, 0, 1);
        rx_dllp("R8", 'hAC);
        idle("R9", 2);
        // R6 boundary: longest legal TLP
        rx_tlp("R6", 1031, 'hFFF, 0, 0, 0);
        rx_tlp("R6", 5, 'h010, 0, 0, 0);

        // R10: illegal start, then R13 halt ignores a valid packet
        e = ex0(); e.err = 1;
        step("R10", 8'h55, 1, 0, e);
        rx_dllp("R13", 'hAC);
        recover();
        // R11: check bits, parity, length range
        rx_tlp("R11", 6, 'h005, 1, 0, 0);
        recover();
        rx_tlp("R11", 6, 'h005, 0, 1, 0);
        recover();
        rx_tlp("R11", 4, 'h005, 0, 0, 0);
        recover();
        rx_tlp("R11", 1032, 'h005, 0, 0, 0);
        recover();
        rx_tlp("R13", 5, 'h777, 0, 0, 0);
        // R12: end-bad in a plain start slot
        idle("R12", 1);
        e = ex0(); e.err = 1;
        step("R12", 8'hC0, 1, 0, e);
        recover();
        // R10: link start not followed by the second symbol
        rx_dllp("R10", 'h12);
        recover();
        // R12: symbol after TLP end that is not a legal start
        rx_tlp("R12", 5, 'h100, 0, 0, 0);
        e = ex0(); e.err = 1;
        step("R12", 8'h77, 1, 0, e);
        recover();
        idle("R13", 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule